// File: doc/BRIEF.md
# Windowed Address Lookup Translator

This block maps inbound memory requests that fall inside a single power-of-two address window onto a 64-bit target address space. It has two modes. In the first, the whole window is moved as one piece onto one programmed target base. In the second, the window is cut into 128 or 256 equal segments. Each segment is redirected to its own 64-bit target base and carries its own read and write permission. A table segment is much smaller than the window, so target bases only have to be aligned to the segment size. Segments can also be closed individually, so that parts of the window refuse access.

Configuration arrives through a simple 32-bit register-write port. That port sets the window size, the single target base, a control word holding the table enable, and the three words of every table entry. A two-bit strap input sets how many table entries this port owns, or whether it owns a table at all. Each request presents a window offset and a read/write flag. One clock later the block returns the translated address and a deny flag.

Top module: `win_xlat`

## Requirements
- R1: After reset the output valid flag is low, the table is off, the window is 1 MB (2^20 bytes) and the single target base is zero.
- R2: Every cycle with `reqValid` high produces `outValid` high exactly one cycle later; a cycle without a request produces `outValid` low one cycle later.
- R3: The entry count comes from `lutStrap`: 2'b11 gives 256 entries, a set bit at position `PORT_SEL` (default 0) alone gives 128 entries, anything else gives no table, and then the enable bit has no effect.
- R4: Bits [6:0] of the register at byte address 0x0000 hold log2 of the window size; values below 20 act as 20, values above `OFF_W` (default 32) act as `OFF_W`; offset bits at or above the window size are ignored.
- R5: In single-base mode the output address is the 64-bit base (low word at 0x0004, high word at 0x0008) with the bits below the window size cleared, OR'ed with the offset inside the window; deny is always 0.
- R6: Bit 28 of the control register at 0x000C turns table mode on (when R3 permits); writing a word with bit 28 clear returns to single-base mode.
- R7: In table mode with N entries, the entry index is the top log2(N) bits of the in-window offset; the address is that entry's 64-bit base with the bits below the segment size cleared, OR'ed with the offset bits below the segment size.
- R8: Entry i has its low base word at 0x8000 + 4*i, plus a further 0x0E00 when i is 128 or above; its high base word sits 0x400 above the low word and its permission word 0x800 above it.
- R9: Permission bit 0 allows reads and bit 1 allows writes; a request whose bit is clear returns `outDeny` = 1 and `outAddr` = 0.
- R10: A register write takes effect for requests issued on the next cycle; a request issued in the same cycle as the write still sees the old value.
- R11: A write to any byte address other than the four configuration registers and the entry words of R8 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lutStrap | input | 2 | Table presence/size strap |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 16 | Register byte address |
| wrData | input | 32 | Register write data |
| reqValid | input | 1 | Request present |
| reqOffset | input | OFF_W | Offset of the request inside the window |
| reqWrite | input | 1 | 1 for a write request, 0 for a read |
| outValid | output | 1 | Translation result present |
| outAddr | output | 64 | Translated address, zero when denied |
| outDeny | output | 1 | Request refused by the entry permission |

## Verification
Single-base mode is tried with unaligned bases and with offsets carrying bits above the window. This separates masking from addition and shows whether the window size is honoured, including the clamped sizes. Table mode is tried under 128 and 256 entries and under two window sizes, with every entry programmed to a distinct base and permission. Randomised offsets then expose any error in the index or the segment split, and any swap between read and write permission. Directed writes cover the upper-bank address shift, aliased addresses that must be ignored, a write that coincides with a request, and strap values that must keep the table off.

// File: rtl/win_xlat_pkg.sv
package win_xlat_pkg;

  // Table geometry: the register map provides room for at most 256 entries.
  localparam int IDX_W     = 8;
  localparam int NUM_ENT   = 1 << IDX_W;
  localparam int SIZE_W    = 7;
  localparam int ENTLOG_W  = 4;
  localparam int PERM_W    = 2;

  // Configuration register byte addresses.
  localparam logic [15:0] SIZE_ADDR   = 16'h0000;
  localparam logic [15:0] BASELO_ADDR = 16'h0004;
  localparam logic [15:0] BASEHI_ADDR = 16'h0008;
  localparam logic [15:0] CTL_ADDR    = 16'h000C;
  localparam int          LUT_EN_BIT  = 28;

  // Entry word groups inside the table region (address bits [11:10]).
  localparam logic [1:0] GRP_LO   = 2'd0;
  localparam logic [1:0] GRP_HI   = 2'd1;
  localparam logic [1:0] GRP_PERM = 2'd2;

  // Strobes from the register decoder to the table.
  typedef struct packed {
    logic             loWe;
    logic             hiWe;
    logic             permWe;
    logic [IDX_W-1:0] idx;
    logic [31:0]      data;
  } tblWrite_t;

  // Live configuration seen by the lookup path.
  typedef struct packed {
    logic                lutOn;
    logic [ENTLOG_W-1:0] entLog2;
    logic [SIZE_W-1:0]   sizeLog2;
    logic [63:0]         base;
  } winCfg_t;

endpackage

// File: rtl/win_xlat_ctrl.sv
module win_xlat_ctrl
  import win_xlat_pkg::*;
#(
  parameter int OFF_W         = 32,
  parameter int PORT_SEL      = 0,
  parameter int MIN_SIZE_LOG2 = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  lutStrap,
  input  logic        wrEn,
  input  logic [15:0] wrAddr,
  input  logic [31:0] wrData,
  output tblWrite_t   tblWr,
  output winCfg_t     cfg
);

  localparam logic [SIZE_W-1:0] SIZE_MIN = SIZE_W'(MIN_SIZE_LOG2);
  localparam logic [SIZE_W-1:0] SIZE_MAX = SIZE_W'(OFF_W);

  logic [SIZE_W-1:0]   sizeRaw;
  logic [SIZE_W-1:0]   sizeEff;
  logic [31:0]         baseLo;
  logic [31:0]         baseHi;
  logic                lutReq;
  logic [ENTLOG_W-1:0] entLog2;

  logic hitSize, hitBaseLo, hitBaseHi, hitCtl;
  logic inTbl;
  logic [1:0] grp;

  // Configuration register decode: exact word addresses only.
  assign hitSize   = wrEn && (wrAddr == SIZE_ADDR);
  assign hitBaseLo = wrEn && (wrAddr == BASELO_ADDR);
  assign hitBaseHi = wrEn && (wrAddr == BASEHI_ADDR);
  assign hitCtl    = wrEn && (wrAddr == CTL_ADDR);

  // Table region: bit 15 set, bits 14:13 clear, bit 9 clear, word aligned.
  // Bit 12 selects the upper bank, bits 11:10 the word group, 8:2 the slot.
  assign grp   = wrAddr[11:10];
  assign inTbl = wrEn && wrAddr[15] && (wrAddr[14:13] == 2'b00) &&
                 !wrAddr[9] && (wrAddr[1:0] == 2'b00) && (grp != 2'b11);

  always_comb begin
    tblWr        = '0;
    tblWr.idx    = {wrAddr[12], wrAddr[8:2]};
    tblWr.data   = wrData;
    tblWr.loWe   = inTbl && (grp == GRP_LO);
    tblWr.hiWe   = inTbl && (grp == GRP_HI);
    tblWr.permWe = inTbl && (grp == GRP_PERM);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sizeRaw <= '0;
      baseLo  <= '0;
      baseHi  <= '0;
      lutReq  <= 1'b0;
    end else begin
      if (hitSize)   sizeRaw <= wrData[SIZE_W-1:0];
      if (hitBaseLo) baseLo  <= wrData;
      if (hitBaseHi) baseHi  <= wrData;
      if (hitCtl)    lutReq  <= wrData[LUT_EN_BIT];
    end
  end

  // Window size clamp.
  always_comb begin
    sizeEff = sizeRaw;
    if (sizeRaw < SIZE_MIN)      sizeEff = SIZE_MIN;
    else if (sizeRaw > SIZE_MAX) sizeEff = SIZE_MAX;
  end

  // Entry count from the strap.
  always_comb begin
    if (lutStrap == 2'b11)       entLog2 = ENTLOG_W'(IDX_W);
    else if (lutStrap[PORT_SEL]) entLog2 = ENTLOG_W'(IDX_W - 1);
    else                         entLog2 = '0;
  end

  always_comb begin
    cfg          = '0;
    cfg.lutOn    = lutReq && (entLog2 != '0);
    cfg.entLog2  = entLog2;
    cfg.sizeLog2 = sizeEff;
    cfg.base     = {baseHi, baseLo};
  end

  AST_SIZE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.sizeLog2 >= SIZE_MIN) && (cfg.sizeLog2 <= SIZE_MAX)); // R4

  AST_NO_STRAP_NO_LUT: assert property (@(posedge clk) disable iff (!rstN)
    !lutStrap[PORT_SEL] |-> !cfg.lutOn); // R3

  AST_CTL_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrAddr == CTL_ADDR) && !wrData[LUT_EN_BIT]) |=> !cfg.lutOn); // R6

endmodule

// File: rtl/win_xlat_dp.sv
module win_xlat_dp
  import win_xlat_pkg::*;
#(
  parameter int OFF_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  tblWrite_t        tblWr,
  input  winCfg_t          cfg,
  input  logic             reqValid,
  input  logic [OFF_W-1:0] reqOffset,
  input  logic             reqWrite,
  output logic             outValid,
  output logic [63:0]      outAddr,
  output logic             outDeny
);

  logic [31:0]       entLoRd   [NUM_ENT];
  logic [31:0]       entHiRd   [NUM_ENT];
  logic [PERM_W-1:0] entPermRd [NUM_ENT];

  // Per-entry storage.
  for (genvar gi = 0; gi < NUM_ENT; gi++) begin : g_ent
    logic [31:0]       lo;
    logic [31:0]       hi;
    logic [PERM_W-1:0] perm;
    logic              sel;

    assign sel = (tblWr.idx == IDX_W'(gi));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lo   <= '0;
        hi   <= '0;
        perm <= '0;
      end else if (sel) begin
        if (tblWr.loWe)   lo   <= tblWr.data;
        if (tblWr.hiWe)   hi   <= tblWr.data;
        if (tblWr.permWe) perm <= tblWr.data[PERM_W-1:0];
      end
    end

    assign entLoRd[gi]   = lo;
    assign entHiRd[gi]   = hi;
    assign entPermRd[gi] = perm;
  end

  // Lookup path.
  logic [63:0]       offExt;
  logic [63:0]       winMask;
  logic [63:0]       offWin;
  logic [SIZE_W-1:0] shiftAmt;
  logic [63:0]       granMask;
  logic [IDX_W-1:0]  idx;
  logic [63:0]       baseSel;
  logic [PERM_W-1:0] permSel;
  logic              permOk;
  logic [63:0]       xlatNext;

  assign offExt  = 64'(reqOffset);
  assign winMask = (64'd1 << cfg.sizeLog2) - 64'd1;
  assign offWin  = offExt & winMask;

  assign shiftAmt = cfg.lutOn ? (cfg.sizeLog2 - SIZE_W'(cfg.entLog2)) : cfg.sizeLog2;
  assign granMask = (64'd1 << shiftAmt) - 64'd1;
  assign idx      = IDX_W'(offWin >> shiftAmt);

  assign permSel = entPermRd[idx];
  assign baseSel = cfg.lutOn ? {entHiRd[idx], entLoRd[idx]} : cfg.base;
  assign permOk  = !cfg.lutOn || (reqWrite ? permSel[1] : permSel[0]);

  assign xlatNext = (baseSel & ~granMask) | (offWin & granMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outAddr  <= '0;
      outDeny  <= 1'b0;
    end else begin
      outValid <= reqValid;
      if (reqValid) begin
        outDeny <= !permOk;
        outAddr <= permOk ? xlatNext : 64'd0;
      end
    end
  end

  AST_REQ_TO_OUT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid); // R2

  AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !outValid); // R2

  AST_DENY_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outDeny) |-> (outAddr == 64'd0)); // R9

  AST_SINGLE_NO_DENY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !cfg.lutOn) |=> !outDeny); // R5

endmodule

// File: rtl/win_xlat.sv
module win_xlat
  import win_xlat_pkg::*;
#(
  parameter int OFF_W         = 32,
  parameter int PORT_SEL      = 0,
  parameter int MIN_SIZE_LOG2 = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       lutStrap,
  input  logic             wrEn,
  input  logic [15:0]      wrAddr,
  input  logic [31:0]      wrData,
  input  logic             reqValid,
  input  logic [OFF_W-1:0] reqOffset,
  input  logic             reqWrite,
  output logic             outValid,
  output logic [63:0]      outAddr,
  output logic             outDeny
);

  tblWrite_t tblWr;
  winCfg_t   cfg;

  win_xlat_ctrl #(
    .OFF_W         (OFF_W),
    .PORT_SEL      (PORT_SEL),
    .MIN_SIZE_LOG2 (MIN_SIZE_LOG2)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .lutStrap (lutStrap),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .tblWr    (tblWr),
    .cfg      (cfg)
  );

  win_xlat_dp #(
    .OFF_W (OFF_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .tblWr     (tblWr),
    .cfg       (cfg),
    .reqValid  (reqValid),
    .reqOffset (reqOffset),
    .reqWrite  (reqWrite),
    .outValid  (outValid),
    .outAddr   (outAddr),
    .outDeny   (outDeny)
  );

endmodule

// File: tb/win_xlat_bench.sv
module win_xlat_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  lutStrap;
  logic        wrEn;
  logic [15:0] wrAddr;
  logic [31:0] wrData;
  logic        reqValid;
  logic [31:0] reqOffset;
  logic        reqWrite;
  logic        outValid;
  logic [63:0] outAddr;
  logic        outDeny;

  always #4 clk = ~clk;

  win_xlat u_win_xlat (
    .clk(clk), .rstN(rstN), .lutStrap(lutStrap),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .reqValid(reqValid), .reqOffset(reqOffset), .reqWrite(reqWrite),
    .outValid(outValid), .outAddr(outAddr), .outDeny(outDeny)
  );

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  // Behavioural register model.
  int unsigned mSizeRaw;
  logic [31:0] mBaseLo, mBaseHi, mCtl;
  logic [31:0] mLo [256];
  logic [31:0] mHi [256];
  logic [31:0] mPerm [256];

  logic [63:0] qAddr [$];
  bit          qDeny [$];
  string       qTag  [$];

  function automatic int entLoAddr(int i);
    return 'h8000 + i * 4 + ((i >= 128) ? 'hE00 : 0);
  endfunction

  function automatic void mReset();
    mSizeRaw = 0; mBaseLo = 0; mBaseHi = 0; mCtl = 0;
    for (int i = 0; i < 256; i++) begin
      mLo[i] = 0; mHi[i] = 0; mPerm[i] = 0;
    end
  endfunction

  function automatic void mWrite(logic [15:0] a, logic [31:0] d);
    int ai;
    ai = int'(a);
    if (ai == 'h0) mSizeRaw = int'(d[6:0]);
    if (ai == 'h4) mBaseLo = d;
    if (ai == 'h8) mBaseHi = d;
    if (ai == 'hC) mCtl = d;
    for (int i = 0; i < 256; i++) begin
      if (ai == entLoAddr(i))               mLo[i]   = d;
      else if (ai == entLoAddr(i) + 'h400)  mHi[i]   = d;
      else if (ai == entLoAddr(i) + 'h800)  mPerm[i] = d;
    end
  endfunction

  function automatic void mLookup(logic [31:0] off, bit isWr,
                                  output logic [63:0] ea, output bit ed);
    int ent, s, g, idx;
    longint unsigned o, lowMask, b;
    bit lut;
    ent = (lutStrap == 2'b11) ? 256 : (lutStrap[0] ? 128 : 0);
    lut = mCtl[28] && (ent != 0);
    s = int'(mSizeRaw);
    if (s < 20) s = 20;
    if (s > 32) s = 32;
    o = {32'd0, off} & ((64'd1 << s) - 64'd1);
    if (!lut) begin
      b = {mBaseHi, mBaseLo};
      lowMask = (64'd1 << s) - 64'd1;
      ed = 0;
    end else begin
      g = s - $clog2(ent);
      idx = int'(o >> g);
      lowMask = (64'd1 << g) - 64'd1;
      b = {mHi[idx], mLo[idx]};
      ed = isWr ? !mPerm[idx][1] : !mPerm[idx][0];
    end
    ea = ed ? 64'd0 : ((b & ~lowMask) | (o & lowMask));
  endfunction

  task automatic check(bit ok, string tag, string act, string exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, compare at the next falling edge.
  task automatic step(bit doWr, logic [15:0] wa, logic [31:0] wd,
                      bit doReq, logic [31:0] off, bit isWr, string tag);
    logic [63:0] ea;
    bit ed;
    wrEn = doWr; wrAddr = wa; wrData = wd;
    reqValid = doReq; reqOffset = off; reqWrite = isWr;
    if (doReq) begin
      mLookup(off, isWr, ea, ed);
      qAddr.push_back(ea); qDeny.push_back(ed); qTag.push_back(tag);
    end
    if (doWr) mWrite(wa, wd);
    @(posedge clk);
    @(negedge clk);
    wrEn = 0; reqValid = 0;
    if (qAddr.size() > 0) begin
      logic [63:0] xa;
      bit xd;
      string xt;
      xa = qAddr.pop_front(); xd = qDeny.pop_front(); xt = qTag.pop_front();
      check(outValid && (outAddr == xa) && (outDeny == xd), xt,
            $sformatf("v=%0b a=%h d=%0b", outValid, outAddr, outDeny),
            $sformatf("v=1 a=%h d=%0b", xa, xd));
    end else begin
      check(!outValid, {tag, " R2 idle"},
            $sformatf("v=%0b", outValid), "v=0");
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d, string tag);
    step(1, a, d, 0, 0, 0, tag);
  endtask

  task automatic rq(logic [31:0] off, bit isWr, string tag);
    step(0, 0, 0, 1, off, isWr, tag);
  endtask

  task automatic setEntry(int i, logic [31:0] lo, logic [31:0] hi, logic [31:0] pm);
    wr(16'(entLoAddr(i)), lo, "R8 wr");
    wr(16'(entLoAddr(i) + 'h400), hi, "R8 wr");
    wr(16'(entLoAddr(i) + 'h800), pm, "R8 wr");
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    int unsigned lcg;
    rstN = 0; lutStrap = 2'b00;
    wrEn = 0; wrAddr = 0; wrData = 0;
    reqValid = 0; reqOffset = 0; reqWrite = 0;
    mReset();
    repeat (3) @(negedge clk);
    check(!outValid && (outAddr == 0) && !outDeny, "R1 reset",
          $sformatf("v=%0b a=%h", outValid, outAddr), "v=0 a=0");
    rstN = 1;
    @(negedge clk);

    // R1: 1 MB window, zero base; offset bit 20 is outside it.
    rq(32'h0011_2345, 0, "R1 default window");
    rq(32'h000F_FFFF, 1, "R1 default write");
    step(0, 0, 0, 0, 0, 0, "R2 gap");

    // R5: unaligned single base, bits below window dropped.
    wr(16'h0004, 32'hABC1_2345, "R5 wr");
    wr(16'h0008, 32'h0000_0001, "R5 wr");
    rq(32'h0000_0010, 0, "R5 single base");
    rq(32'hFFFF_FFFF, 1, "R5 single base high bits");

    // R4: size register and clamping.
    wr(16'h0000, 32'd24, "R4 wr");
    rq(32'h0123_4567, 0, "R4 size 24");
    wr(16'h0000, 32'd5, "R4 wr");
    rq(32'h0123_4567, 0, "R4 clamp low");
    wr(16'h0000, 32'd40, "R4 wr");
    rq(32'h8123_4567, 0, "R4 clamp high");

    // R3: no strap, enable has no effect.
    wr(16'h0000, 32'd24, "R4 wr");
    setEntry(0, 32'h5555_0000, 32'h7, 32'h0);
    wr(16'h000C, 32'h1000_0000, "R6 wr");
    rq(32'h0000_0040, 0, "R3 no strap single base");
    lutStrap = 2'b10;
    rq(32'h0000_0040, 0, "R3 other port bit only");

    // R3/R7: 128 entries, size 24 -> 128 KB segments.
    lutStrap = 2'b01;
    setEntry(0,   32'h1000_0123, 32'h0000_00AA, 32'h3);
    setEntry(5,   32'h2000_0000, 32'h0000_00BB, 32'h1);
    setEntry(127, 32'h3FFE_0000, 32'h0000_00CC, 32'h2);
    rq(32'h0000_0040, 0, "R7 entry 0 unaligned base");
    rq(32'h000A_1234, 0, "R7 entry 5 read");
    rq(32'h000A_1234, 1, "R9 entry 5 write denied");
    rq(32'h00FF_FFF0, 1, "R9 entry 127 write allowed");
    rq(32'h00FF_FFF0, 0, "R9 entry 127 read denied");
    rq(32'h0004_0000, 0, "R9 entry 2 perm zero");
    rq(32'hFF00_0040, 0, "R4 offset bits above window ignored");

    // R10: write and request in the same cycle.
    step(1, 16'(entLoAddr(5)), 32'h4400_0000, 1, 32'h000A_0008, 0, "R10 same cycle old");
    rq(32'h000A_0008, 0, "R10 next cycle new");

    // R11: aliased and unused addresses.
    wr(16'h8600, 32'hDEAD_BEEF, "R11 wr");
    wr(16'h8C00, 32'hDEAD_BEEF, "R11 wr");
    wr(16'h8002, 32'hDEAD_BEEF, "R11 wr");
    wr(16'h0010, 32'd30, "R11 wr");
    wr(16'hA000, 32'hDEAD_BEEF, "R11 wr");
    rq(32'h0000_0040, 0, "R11 entry 0 untouched");

    // R3/R8: 256 entries, upper bank addressing.
    lutStrap = 2'b11;
    setEntry(128, 32'h0808_0000, 32'h0000_0128, 32'h3);
    setEntry(255, 32'h0FF0_0000, 32'h0000_0255, 32'h3);
    rq(32'h0080_0010, 0, "R8 entry 128");
    rq(32'h00FF_FF00, 1, "R8 entry 255");
    rq(32'h0000_0010, 0, "R3 256 entries entry 0");

    // R7: every entry distinct, random offsets, two sizes, both counts.
    for (int i = 0; i < 256; i++)
      setEntry(i, 32'(i) * 32'h0013_1000 + 32'h55, 32'(i) ^ 32'hA5, 32'(i % 4));
    lcg = 32'h1234_5678;
    for (int k = 0; k < 200; k++) begin
      lcg = lcg * 1664525 + 1013904223;
      rq(lcg, lcg[7], "R7 random 256 size 24");
    end
    wr(16'h0000, 32'd20, "R4 wr");
    for (int k = 0; k < 200; k++) begin
      lcg = lcg * 1664525 + 1013904223;
      rq(lcg, lcg[9], "R7 random 256 size 20");
    end
    lutStrap = 2'b01;
    wr(16'h0000, 32'd31, "R4 wr");
    for (int k = 0; k < 200; k++) begin
      lcg = lcg * 1664525 + 1013904223;
      rq(lcg, lcg[11], "R7 random 128 size 31");
    end

    // R6: back to single base.
    wr(16'h000C, 32'h0000_0000, "R6 wr");
    rq(32'h1234_5678, 1, "R6 disabled single base");
    wr(16'h000C, 32'h1000_0000, "R6 wr");
    rq(32'h1234_5678, 1, "R6 re-enabled");
    step(0, 0, 0, 0, 0, 0, "R2 tail");

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule